// File: doc/BRIEF.md
# SATA Link Transmit Handshake Sequencer

This block is the transmit half of a serial storage link layer, working one 32-bit dword per clock. When the transport side has a frame waiting in its show-ahead FIFO, the block announces the frame and waits for the far end to say it can receive. It then opens the frame with the start primitive and streams the payload, scrambled and followed by a CRC dword. It closes the frame with the end primitive and keeps sending the wait-for-termination primitive until the receiver returns a final status. The transport side sees a busy level and a single done pulse per frame, with an error flag on that pulse.

Each output dword has a flag that marks byte 0 (bits 7:0, sent first on the wire) as a control character. Primitives carry the flag and are never scrambled. Payload and CRC dwords go out as data. The scrambler keystream and the CRC value come from two small stub modules. The keystream restarts at every start primitive. The CRC stub is a running XOR, standing in for the real polynomial engine. A free-running timer replaces two output slots out of every `ALIGN_PERIOD` with ALIGN primitives, even in the middle of a frame, and the frame is not disturbed.

The transport side is expected to keep payload dwords available once a frame has started. If the FIFO runs dry mid-frame, SYNC fills the slot and nothing advances.

Top module: `sata_link_tx`

## Requirements
- R1: During and after reset, with no frame pending, the block sends SYNC (0xB5B5957C, control flag 1). busy, done, err and frm_pop are low.
- R2: When frm_valid is seen while idle, the block sends X_RDY (0x5757B57C) on every slot until R_RDY (0x4A4A957C, control flag 1) is received. The next non-ALIGN dword is then SOF (0x3737B57C, bytes K28.3, D21.5, D23.1, D23.1 from bit 7:0 upward).
- R3: Payload dwords follow SOF in FIFO order with control flag 0. Dword i is sent as data XOR key_i, where key_0 = SCR_SEED and key_(i+1) = {key_i[30:0],0} XOR (key_i[31] ? SCR_POLY : 0).
- R4: After the last payload dword the block sends the CRC dword: CRC_INIT XORed with every unscrambled payload dword, then XORed with key_n, flag 0. It then sends EOF (0xD5D5B57C), then WTRM (0x5858B57C) on every slot until a final status arrives.
- R5: On receiving R_OK (0x3535B57C) during the wait, done pulses for exactly one cycle with err low. In the same cycle busy falls and SYNC is sent. busy is high from the first X_RDY until that cycle.
- R6: On receiving R_ERR (0x5656B57C) during the wait, done pulses once with err high. err is never high without done.
- R7: ALIGN (0x7B4A4ABC, bytes K28.5, D10.2, D10.2, D27.3) goes out as back-to-back pairs. The start of one pair is exactly ALIGN_PERIOD dwords after the start of the previous one, whatever the frame state, and ALIGN_PERIOD must not exceed 2048.
- R8: An ALIGN pair inside a frame does not pop the FIFO, advance the keystream or change the CRC. frm_pop is high for exactly one cycle per payload dword, and each pop is followed by a data dword on the next cycle.
- R9: If no R_RDY arrives, the block sends exactly WDOG_LIMIT X_RDY dwords and then ends the frame with done and err high. If no final status arrives, it sends EOF plus exactly WDOG_LIMIT-1 WTRM dwords and then does the same. ALIGN slots do not count toward either limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock, one dword per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Transport FIFO holds a payload dword at its head |
| frm_data | input | 32 | Payload dword at the FIFO head |
| frm_last | input | 1 | Head dword is the last of the frame |
| frm_pop | output | 1 | Head dword is consumed at this clock edge |
| rx_dword | input | 32 | Dword currently received from the far end |
| rx_kchar | input | 1 | Byte 0 of rx_dword is a control character |
| tx_dword | output | 32 | Dword to transmit, byte 0 first |
| tx_kchar | output | 1 | Byte 0 of tx_dword is a control character |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |
| err | output | 1 | Frame ended in error; valid with done |

## Verification
A keystream register that advances at the wrong time corrupts every later payload dword and the CRC dword of the same frame. This shows at the ports within one dword of the fault, and most easily right after an ALIGN pair that falls inside a frame. A sequencer state that goes wrong shows up as a missing or repeated primitive in the very next slot. A wrong count in the ALIGN timer or the watchdog shows up as a shifted pair or a shifted abort. The bench counts slots exactly, so a timing error of a single cycle is visible.

// File: rtl/sata_tx_pkg.sv
`timescale 1ns/1ps
package sata_tx_pkg;
    localparam int DWORD_W = 32;

    // Primitive dwords, byte 0 (bits 7:0) is the control character sent first.
    localparam logic [DWORD_W-1:0] PRIM_SYNC  = 32'hB5B5_957C;
    localparam logic [DWORD_W-1:0] PRIM_X_RDY = 32'h5757_B57C;
    localparam logic [DWORD_W-1:0] PRIM_R_RDY = 32'h4A4A_957C;
    localparam logic [DWORD_W-1:0] PRIM_SOF   = 32'h3737_B57C;
    localparam logic [DWORD_W-1:0] PRIM_EOF   = 32'hD5D5_B57C;
    localparam logic [DWORD_W-1:0] PRIM_WTRM  = 32'h5858_B57C;
    localparam logic [DWORD_W-1:0] PRIM_R_OK  = 32'h3535_B57C;
    localparam logic [DWORD_W-1:0] PRIM_R_ERR = 32'h5656_B57C;
    localparam logic [DWORD_W-1:0] PRIM_ALIGN = 32'h7B4A_4ABC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ANNOUNCE,
        ST_PAYLOAD,
        ST_CHECK,
        ST_CLOSE,
        ST_AWAIT
    } tx_state_e;
endpackage

// File: rtl/sata_tx_scrambler.sv
`timescale 1ns/1ps
module sata_tx_scrambler #(
    parameter int          W    = 32,
    parameter logic [31:0] SEED = 32'hC2D2_768D,
    parameter logic [31:0] POLY = 32'hA300_0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reseed,
    input  logic         advance,
    output logic [W-1:0] mask
);
    logic [W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (reseed)
            mask_d = SEED[W-1:0];
        else if (advance)
            mask_d = {mask_q[W-2:0], 1'b0} ^ (mask_q[W-1] ? POLY[W-1:0] : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= SEED[W-1:0];
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;
endmodule

// File: rtl/sata_tx_crc_acc.sv
`timescale 1ns/1ps
module sata_tx_crc_acc #(
    parameter int          W    = 32,
    parameter logic [31:0] INIT = 32'h5A5A_0F0F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         accumulate,
    input  logic [W-1:0] din,
    output logic [W-1:0] value
);
    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear)           acc_d = INIT[W-1:0];
        else if (accumulate) acc_d = acc_q ^ din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= INIT[W-1:0];
        else        acc_q <= acc_d;
    end

    assign value = acc_q;
endmodule

// File: rtl/sata_tx_align_timer.sv
`timescale 1ns/1ps
module sata_tx_align_timer #(
    parameter int PERIOD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 2;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign slot = (cnt_q >= CW'(PERIOD - 2));
endmodule

// File: rtl/sata_link_tx.sv
`timescale 1ns/1ps
module sata_link_tx
    import sata_tx_pkg::*;
#(
    parameter int          ALIGN_PERIOD = 1024,
    parameter int          WDOG_LIMIT   = 4096,
    parameter logic [31:0] SCR_SEED     = 32'hC2D2_768D,
    parameter logic [31:0] SCR_POLY     = 32'hA300_0001,
    parameter logic [31:0] CRC_INIT     = 32'h5A5A_0F0F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_valid,
    input  logic [31:0] frm_data,
    input  logic        frm_last,
    output logic        frm_pop,
    input  logic [31:0] rx_dword,
    input  logic        rx_kchar,
    output logic [31:0] tx_dword,
    output logic        tx_kchar,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam int WDW = (WDOG_LIMIT > 2) ? $clog2(WDOG_LIMIT) : 1;

    typedef struct packed {
        tx_state_e          state;
        logic [DWORD_W-1:0] tx_dword;
        logic               tx_kchar;
        logic               busy;
        logic               done;
        logic               err;
        logic [WDW-1:0]     wd;
    } regs_t;

    regs_t r_d, r_q;

    logic               align_slot;
    logic [DWORD_W-1:0] key;
    logic [DWORD_W-1:0] crc_val;
    logic               scr_reseed, scr_advance, crc_clear, crc_accum, pop_d;
    logic               rx_rdy, rx_ok, rx_bad, wd_expire;

    sata_tx_align_timer #(.PERIOD(ALIGN_PERIOD)) u_align (
        .clk(clk), .rst_n(rst_n), .slot(align_slot)
    );

    sata_tx_scrambler #(.W(DWORD_W), .SEED(SCR_SEED), .POLY(SCR_POLY)) u_scr (
        .clk(clk), .rst_n(rst_n), .reseed(scr_reseed), .advance(scr_advance), .mask(key)
    );

    sata_tx_crc_acc #(.W(DWORD_W), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear(crc_clear), .accumulate(crc_accum),
        .din(frm_data), .value(crc_val)
    );

    assign rx_rdy    = rx_kchar && (rx_dword == PRIM_R_RDY);
    assign rx_ok     = rx_kchar && (rx_dword == PRIM_R_OK);
    assign rx_bad    = rx_kchar && (rx_dword == PRIM_R_ERR);
    assign wd_expire = (r_q.wd == WDW'(WDOG_LIMIT - 1));

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        scr_reseed  = 1'b0;
        scr_advance = 1'b0;
        crc_clear   = 1'b0;
        crc_accum   = 1'b0;
        pop_d       = 1'b0;

        if (align_slot) begin
            // Slot taken by ALIGN: every piece of frame state holds.
            r_d.tx_dword = PRIM_ALIGN;
            r_d.tx_kchar = 1'b1;
        end else begin
            r_d.tx_kchar = 1'b1;
            unique case (r_q.state)
                ST_IDLE: begin
                    if (frm_valid) begin
                        r_d.tx_dword = PRIM_X_RDY;
                        r_d.state    = ST_ANNOUNCE;
                        r_d.wd       = '0;
                    end else begin
                        r_d.tx_dword = PRIM_SYNC;
                    end
                end
                ST_ANNOUNCE: begin
                    if (rx_rdy) begin
                        r_d.tx_dword = PRIM_SOF;
                        r_d.state    = ST_PAYLOAD;
                        scr_reseed   = 1'b1;
                        crc_clear    = 1'b1;
                    end else if (wd_expire) begin
                        r_d.tx_dword = PRIM_SYNC;
                        r_d.state    = ST_IDLE;
                        r_d.done     = 1'b1;
                        r_d.err      = 1'b1;
                    end else begin
                        r_d.tx_dword = PRIM_X_RDY;
                        r_d.wd       = r_q.wd + 1'b1;
                    end
                end
                ST_PAYLOAD: begin
                    if (frm_valid) begin
                        r_d.tx_dword = frm_data ^ key;
                        r_d.tx_kchar = 1'b0;
                        pop_d        = 1'b1;
                        scr_advance  = 1'b1;
                        crc_accum    = 1'b1;
                        if (frm_last) r_d.state = ST_CHECK;
                    end else begin
                        r_d.tx_dword = PRIM_SYNC;
                    end
                end
                ST_CHECK: begin
                    r_d.tx_dword = crc_val ^ key;
                    r_d.tx_kchar = 1'b0;
                    scr_advance  = 1'b1;
                    r_d.state    = ST_CLOSE;
                end
                ST_CLOSE: begin
                    r_d.tx_dword = PRIM_EOF;
                    r_d.state    = ST_AWAIT;
                    r_d.wd       = '0;
                end
                ST_AWAIT: begin
                    if (rx_ok || rx_bad) begin
                        r_d.tx_dword = PRIM_SYNC;
                        r_d.state    = ST_IDLE;
                        r_d.done     = 1'b1;
                        r_d.err      = rx_bad;
                    end else if (wd_expire) begin
                        r_d.tx_dword = PRIM_SYNC;
                        r_d.state    = ST_IDLE;
                        r_d.done     = 1'b1;
                        r_d.err      = 1'b1;
                    end else begin
                        r_d.tx_dword = PRIM_WTRM;
                        r_d.wd       = r_q.wd + 1'b1;
                    end
                end
                default: begin
                    r_d.tx_dword = PRIM_SYNC;
                    r_d.state    = ST_IDLE;
                end
            endcase
        end
        r_d.busy = (r_d.state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.tx_dword <= PRIM_SYNC;
            r_q.tx_kchar <= 1'b1;
            r_q.busy     <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.err      <= 1'b0;
            r_q.wd       <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign frm_pop  = pop_d;
    assign tx_dword = r_q.tx_dword;
    assign tx_kchar = r_q.tx_kchar;
    assign busy     = r_q.busy;
    assign done     = r_q.done;
    assign err      = r_q.err;
endmodule

// File: rtl/sata_link_tx_chk.sv
`timescale 1ns/1ps
module sata_link_tx_chk
    import sata_tx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        frm_pop,
    input logic [31:0] tx_dword,
    input logic        tx_kchar,
    input logic        busy,
    input logic        done,
    input logic        err
);
    logic is_align;
    assign is_align = tx_kchar && (tx_dword == PRIM_ALIGN);

    assert_idle_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_kchar && (tx_dword == PRIM_SYNC || tx_dword == PRIM_ALIGN)));

    assert_data_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_kchar |-> busy);

    assert_single_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_align_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_align && !$past(is_align)) |=> is_align);

    assert_align_max_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_align && $past(is_align)) |=> !is_align);

    assert_pop_gives_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_pop |=> !tx_kchar);
endmodule

bind sata_link_tx sata_link_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frm_pop(frm_pop), .tx_dword(tx_dword),
    .tx_kchar(tx_kchar), .busy(busy), .done(done), .err(err)
);

// File: tb/sata_link_tx_tb.sv
`timescale 1ns/1ps
module sata_link_tx_tb;
    import sata_tx_pkg::*;

    localparam int          P     = 32;
    localparam int          LIM   = 24;
    localparam logic [31:0] SEED  = 32'hC2D2_768D;
    localparam logic [31:0] POLY  = 32'hA300_0001;
    localparam logic [31:0] CINIT = 32'h5A5A_0F0F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frm_valid, frm_last, frm_pop;
    logic [31:0] frm_data;
    logic [31:0] rx_dword;
    logic        rx_kchar;
    logic [31:0] tx_dword;
    logic        tx_kchar, busy, done, err;

    always #4 clk = ~clk;

    sata_link_tx #(.ALIGN_PERIOD(P), .WDOG_LIMIT(LIM), .SCR_SEED(SEED),
                   .SCR_POLY(POLY), .CRC_INIT(CINIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_last(frm_last), .frm_pop(frm_pop), .rx_dword(rx_dword), .rx_kchar(rx_kchar),
        .tx_dword(tx_dword), .tx_kchar(tx_kchar), .busy(busy), .done(done), .err(err)
    );

    // Transport FIFO model
    logic [31:0] pl [0:63];
    int          flen = 0;
    int          idx = 0;
    int          pops = 0;
    logic        frm_en = 1'b0;
    logic        idx_clr = 1'b0;

    always_comb begin
        frm_valid = frm_en && (idx < flen);
        frm_data  = (idx < 64) ? pl[idx] : 32'h0;
        frm_last  = (idx == flen - 1);
    end

    always @(posedge clk) begin
        if (idx_clr) begin
            idx  <= 0;
            pops <= 0;
        end else if (frm_pop) begin
            idx  <= idx + 1;
            pops <= pops + 1;
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] kstep(input logic [31:0] m);
        return {m[30:0], 1'b0} ^ (m[31] ? POLY : 32'h0);
    endfunction

    // Captured non-ALIGN transmit stream of one frame
    logic [31:0] got_d [$];
    bit          got_k [$];
    int          done_cnt, err_at_done, busy_at_done, aligns_in_frame;

    function automatic logic [31:0] gd(input int p);
        return (p < got_d.size()) ? got_d[p] : 32'hDEAD_BEEF;
    endfunction
    function automatic bit gk(input int p);
        return (p < got_k.size()) ? got_k[p] : 1'b0;
    endfunction

    // mode: 0 = R_OK, 1 = R_ERR, 2 = never R_RDY, 3 = never final status
    task automatic send_frame(input int len, input int mode, input logic [7:0] base);
        bit seen_eof = 0, in_frame = 0;
        int wait_cnt = 0;
        for (int i = 0; i < 64; i++)
            pl[i] = {8'(i), base, ~8'(i), 8'(i * 7 + 3)};
        got_d.delete();
        got_k.delete();
        done_cnt = 0; err_at_done = 0; busy_at_done = 1; aligns_in_frame = 0;
        flen = len;
        rx_dword = PRIM_SYNC; rx_kchar = 1'b1;
        idx_clr = 1'b1;
        @(negedge clk);
        idx_clr = 1'b0;
        frm_en = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (tx_kchar && tx_dword == PRIM_ALIGN) begin
                if (in_frame) aligns_in_frame++;
            end else begin
                got_d.push_back(tx_dword);
                got_k.push_back(tx_kchar);
            end
            if (tx_kchar && tx_dword == PRIM_X_RDY && mode != 2) rx_dword = PRIM_R_RDY;
            if (tx_kchar && tx_dword == PRIM_SOF) begin
                rx_dword = PRIM_SYNC ^ 32'h0000_2000; // R_IP stand-in, not a status
                rx_dword = 32'h5555_B57C;
                in_frame = 1;
            end
            if (tx_kchar && tx_dword == PRIM_EOF) begin
                seen_eof = 1;
                in_frame = 0;
            end
            if (seen_eof) begin
                wait_cnt++;
                if (wait_cnt >= 3 && mode == 0) rx_dword = PRIM_R_OK;
                if (wait_cnt >= 3 && mode == 1) rx_dword = PRIM_R_ERR;
            end
            if (done) begin
                done_cnt++;
                err_at_done = err;
                busy_at_done = busy;
                break;
            end
        end
        frm_en = 1'b0;
        rx_dword = PRIM_SYNC;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) done_cnt++;
        end
    endtask

    // Check a completed frame that reached SOF and a final status
    task automatic verify_frame(input int len, input bit exp_err, input string tag);
        int p = 0, xr = 0, wt = 0, bad = 0;
        logic [31:0] m = SEED, c = CINIT;
        while (p < got_d.size() && got_k[p] && got_d[p] == PRIM_X_RDY) begin
            xr++; p++;
        end
        check(xr >= 1, "R2", xr, 1, {tag, " X_RDY announces frame"});
        check(gk(p) && gd(p) == PRIM_SOF, "R2", gd(p), PRIM_SOF, {tag, " SOF after R_RDY"});
        p++;
        for (int i = 0; i < len; i++) begin
            if (gk(p) || gd(p) != (pl[i] ^ m)) bad++;
            c = c ^ pl[i];
            m = kstep(m);
            p++;
        end
        check(bad == 0, "R3", bad, 0, {tag, " scrambled payload mismatches"});
        check(!gk(p) && gd(p) == (c ^ m), "R4", gd(p), c ^ m, {tag, " CRC dword"});
        p++;
        check(gk(p) && gd(p) == PRIM_EOF, "R4", gd(p), PRIM_EOF, {tag, " EOF"});
        p++;
        while (p < got_d.size() && got_k[p] && got_d[p] == PRIM_WTRM) begin
            wt++; p++;
        end
        check(wt >= 1, "R4", wt, 1, {tag, " WTRM during wait"});
        check(gk(p) && gd(p) == PRIM_SYNC, "R5", gd(p), PRIM_SYNC, {tag, " SYNC at done"});
        check(done_cnt == 1, "R5", done_cnt, 1, {tag, " done pulse count"});
        check(busy_at_done == 0, "R5", busy_at_done, 0, {tag, " busy low at done"});
        check(err_at_done == exp_err, exp_err ? "R6" : "R5", err_at_done, exp_err, {tag, " err at done"});
        check(pops == len, "R8", pops, len, {tag, " one pop per payload dword"});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        rx_dword = PRIM_SYNC; rx_kchar = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_dword == PRIM_SYNC && tx_kchar, "R1", tx_dword, PRIM_SYNC, "SYNC in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_dword == PRIM_SYNC && tx_kchar, "R1", tx_dword, PRIM_SYNC, "SYNC after reset");
        check({busy, done, err, frm_pop} == 4'b0, "R1", {busy, done, err, frm_pop}, 0, "status low");
    endtask

    task automatic t_frame_ok;
        send_frame(4, 0, 8'hA1);
        verify_frame(4, 1'b0, "short ok");
    endtask

    task automatic t_frame_err;
        send_frame(1, 1, 8'h5C);
        verify_frame(1, 1'b1, "single err");
    endtask

    task automatic t_long_frame;
        send_frame(48, 0, 8'h3E);
        check(aligns_in_frame >= 2, "R8", aligns_in_frame, 2, "ALIGN pair fell inside frame");
        verify_frame(48, 1'b0, "long ok");
    endtask

    task automatic t_align_idle;
        int first = -1, prev = -1, run = 0, bad_gap = 0, bad_run = 0, starts = 0, other = 0;
        for (int c = 0; c < 4 * P + 2; c++) begin
            @(negedge clk);
            if (tx_kchar && tx_dword == PRIM_ALIGN) begin
                if (run == 0) begin
                    starts++;
                    if (prev >= 0 && c - prev != P) bad_gap++;
                    prev = c;
                    if (first < 0) first = c;
                end
                run++;
            end else begin
                if (run != 0 && run != 2) bad_run++;
                run = 0;
                if (!(tx_kchar && tx_dword == PRIM_SYNC)) other++;
            end
        end
        check(other == 0, "R1", other, 0, "idle dwords other than SYNC/ALIGN");
        check(starts >= 3, "R7", starts, 3, "ALIGN pairs seen");
        check(bad_gap == 0, "R7", bad_gap, 0, "ALIGN pair spacing");
        check(bad_run == 0, "R7", bad_run, 0, "ALIGN run length");
    endtask

    task automatic t_wd_rdy;
        int xr = 0;
        send_frame(3, 2, 8'h77);
        foreach (got_d[i]) if (got_k[i] && got_d[i] == PRIM_X_RDY) xr++;
        check(xr == LIM, "R9", xr, LIM, "X_RDY count before abort");
        check(done_cnt == 1 && err_at_done == 1, "R9", {done_cnt[15:0], 16'(err_at_done)}, 32'h0001_0001, "abort without R_RDY");
        check(pops == 0, "R9", pops, 0, "no pop on aborted announce");
    endtask

    task automatic t_wd_final;
        int wt = 0;
        send_frame(2, 3, 8'h19);
        foreach (got_d[i]) if (got_k[i] && got_d[i] == PRIM_WTRM) wt++;
        check(wt == LIM - 1, "R9", wt, LIM - 1, "WTRM count before abort");
        check(done_cnt == 1 && err_at_done == 1, "R9", {done_cnt[15:0], 16'(err_at_done)}, 32'h0001_0001, "abort without status");
    endtask

    initial begin
        t_reset();
        t_align_idle();
        t_frame_ok();
        t_frame_err();
        t_long_frame();
        t_wd_rdy();
        t_wd_final();
        t_frame_ok();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule